// File: doc/BRIEF.md
# I2C Target Address Range Matcher

This block decides whether the 7-bit address carried in the first byte after a START condition selects the local target. It holds three registers, loaded through a small register write port: a primary target address, a secondary (range) address and a configuration word. The configuration word enables window matching and matching of the SMBus alert response address. Other logic captures the address byte and presents it with a one-cycle valid strobe. One clock later the block answers with a one-cycle match pulse and a 2-bit code that names the rule that fired. A register read port returns the stored values.

The secondary address is active only while it holds a nonzero address, so it can be switched off by writing zero. When window mode is on, it stops being a second exact address. It becomes the inclusive upper limit of a window whose lower limit is the primary address. The alert response address is fixed at 7'b0001100 and is matched only while its enable bit is set.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After reset every register reads zero, window mode and alert matching are off and the secondary address is disabled. Only the primary address (zero) is compared.
- R2: A valid address whose bits [7:1] equal the primary address gives match_pulse=1 with match_kind=2'b01 in the next cycle.
- R3: Writing the secondary register (rd/wr select 2'b01) with nonzero bits [7:1] enables it. With window mode off, an equal address then gives match_kind=2'b10.
- R4: Writing the secondary register with bits [7:1] equal to zero disables it, whatever bit 0 holds. No address then matches through it.
- R5: Bit 0 of the primary (select 2'b00) and secondary address registers always reads 0, and writes to it are ignored. Address bits [7:1] are stored in bits [7:1].
- R6: With window mode on (configuration select 2'b10, bit 0), an enabled secondary address makes every address in the range from the primary address to the secondary address, both ends included, give match_kind=2'b10. The primary address itself still gives 2'b01. When the secondary address is below the primary address, the window is empty.
- R7: With alert enable (configuration bit 1) set, address 7'b0001100 gives match_kind=2'b11. With it clear, that address does not match.
- R8: When several rules match the same address, the primary rule wins over the secondary/window rule, which wins over the alert rule.
- R9: match_pulse is high for exactly one cycle, only in the cycle after addr_valid, and only when a rule matched. match_kind is 2'b00 whenever match_pulse is low.
- R10: The read/write bit (addr_byte[0]) has no effect on matching.
- R11: A register write and an address strobe in the same cycle compare against the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register written: 00 primary, 01 secondary, 10 configuration |
| wr_data | input | 8 | Write data |
| rd_sel | input | 2 | Register read back, same encoding as wr_sel |
| rd_data | output | 8 | Read data (configuration: bit 0 window mode, bit 1 alert enable) |
| addr_valid | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Address in bits [7:1], read/write bit in bit 0 |
| match_pulse | output | 1 | One-cycle match indication |
| match_kind | output | 2 | 00 none, 01 primary, 10 secondary/window, 11 alert |

## Verification
A corrupted address or enable register shows up at the read port in the very next cycle. It also shows up as a missing or wrongly coded match on the first strobe that probes it, one cycle after that strobe. The secondary enable flag cannot be read back, so it is checked only through matching: addresses equal to the stored value must stop matching after a zero write. The stimulus probes both window limits, the addresses just outside them, and overlapping rules. A faulty comparison boundary or a wrong priority therefore changes match_kind on a specific, known strobe.

// File: rtl/amatch_pkg.sv
package amatch_pkg;
    localparam int TGT_W  = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        KIND_NONE    = 2'd0,
        KIND_PRIMARY = 2'd1,
        KIND_RANGE   = 2'd2,
        KIND_ALERT   = 2'd3
    } match_kind_e;

    typedef enum logic [1:0] {
        SEL_PRIMARY = 2'd0,
        SEL_RANGE   = 2'd1,
        SEL_CONFIG  = 2'd2,
        SEL_UNUSED  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [TGT_W-1:0] prim;
        logic [TGT_W-1:0] rng;
        logic             rng_en;
        logic             win_mode;
        logic             alert_en;
    } amatch_regs_t;

    typedef struct packed {
        logic        pulse;
        match_kind_e kind;
    } amatch_out_t;
endpackage

// File: rtl/amatch_regs.sv
module amatch_regs
    import amatch_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output amatch_regs_t      regs
);
    localparam int CFG_PAD = BYTE_W - 2;

    amatch_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_PRIMARY: r_d.prim = wr_data[BYTE_W-1:1];
                SEL_RANGE: begin
                    r_d.rng    = wr_data[BYTE_W-1:1];
                    r_d.rng_en = |wr_data[BYTE_W-1:1];
                end
                SEL_CONFIG: begin
                    r_d.win_mode = wr_data[0];
                    r_d.alert_en = wr_data[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_PRIMARY: rd_data = {r_q.prim, 1'b0};
            SEL_RANGE:   rd_data = {r_q.rng, 1'b0};
            SEL_CONFIG:  rd_data = {{CFG_PAD{1'b0}}, r_q.alert_en, r_q.win_mode};
            default:     rd_data = '0;
        endcase
    end

    assign regs = r_q;
endmodule

// File: rtl/amatch_cmp.sv
module amatch_cmp
    import amatch_pkg::*;
#(
    parameter logic [TGT_W-1:0] ALERT_ADDR = 7'b0001100
) (
    input  amatch_regs_t     regs,
    input  logic [TGT_W-1:0] tgt,
    output match_kind_e      kind
);
    logic hit_prim, hit_win, hit_eq, hit_sec, hit_alert;

    always_comb begin
        hit_prim  = (tgt == regs.prim);
        hit_win   = (tgt >= regs.prim) && (tgt <= regs.rng);
        hit_eq    = (tgt == regs.rng);
        hit_sec   = regs.rng_en && (regs.win_mode ? hit_win : hit_eq);
        hit_alert = regs.alert_en && (tgt == ALERT_ADDR);
        if (hit_prim)       kind = KIND_PRIMARY;
        else if (hit_sec)   kind = KIND_RANGE;
        else if (hit_alert) kind = KIND_ALERT;
        else                kind = KIND_NONE;
    end
endmodule

// File: rtl/amatch_out.sv
module amatch_out
    import amatch_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strobe,
    input  match_kind_e kind,
    output logic        pulse,
    output logic [1:0]  kind_out
);
    amatch_out_t o_d, o_q;

    always_comb begin
        o_d.pulse = strobe && (kind != KIND_NONE);
        o_d.kind  = o_d.pulse ? kind : KIND_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '{pulse: 1'b0, kind: KIND_NONE};
        else        o_q <= o_d;
    end

    assign pulse    = o_q.pulse;
    assign kind_out = o_q.kind;
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
    import amatch_pkg::*;
#(
    parameter logic [TGT_W-1:0] ALERT_ADDR = 7'b0001100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              addr_valid,
    input  logic [BYTE_W-1:0] addr_byte,
    output logic              match_pulse,
    output logic [1:0]        match_kind
);
    amatch_regs_t regs;
    match_kind_e  kind_now;

    amatch_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .regs    (regs)
    );

    amatch_cmp #(.ALERT_ADDR(ALERT_ADDR)) u_cmp (
        .regs (regs),
        .tgt  (addr_byte[BYTE_W-1:1]),
        .kind (kind_now)
    );

    amatch_out u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (addr_valid),
        .kind     (kind_now),
        .pulse    (match_pulse),
        .kind_out (match_kind)
    );
endmodule

// File: rtl/amatch_checker.sv
module amatch_checker
    import amatch_pkg::*;
#(
    parameter logic [TGT_W-1:0] ALERT_ADDR = 7'b0001100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              addr_valid,
    input logic [BYTE_W-1:0] addr_byte,
    input logic              match_pulse,
    input logic [1:0]        match_kind,
    input logic [1:0]        rd_sel,
    input logic [BYTE_W-1:0] rd_data,
    input logic [TGT_W-1:0]  prim_q,
    input logic [TGT_W-1:0]  rng_q,
    input logic              rng_en_q,
    input logic              alert_en_q
);
    AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> $past(addr_valid)); // R9
    AST_IDLE_KIND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !match_pulse |-> (match_kind == 2'd0)); // R9
    AST_RSVD_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel != 2'd2) |-> (rd_data[0] == 1'b0)); // R5
    AST_PRIMARY_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (match_pulse && match_kind == 2'd1) |-> ($past(addr_byte[BYTE_W-1:1]) == $past(prim_q))); // R2
    AST_WINDOW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (match_pulse && match_kind == 2'd2) |-> ($past(rng_en_q) && ($past(addr_byte[BYTE_W-1:1]) <= $past(rng_q)))); // R6
    AST_ALERT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (match_pulse && match_kind == 2'd3) |-> ($past(alert_en_q) && ($past(addr_byte[BYTE_W-1:1]) == ALERT_ADDR))); // R7
endmodule

bind i2c_addr_matcher amatch_checker #(.ALERT_ADDR(ALERT_ADDR)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_valid  (addr_valid),
    .addr_byte   (addr_byte),
    .match_pulse (match_pulse),
    .match_kind  (match_kind),
    .rd_sel      (rd_sel),
    .rd_data     (rd_data),
    .prim_q      (regs.prim),
    .rng_q       (regs.rng),
    .rng_en_q    (regs.rng_en),
    .alert_en_q  (regs.alert_en)
);

// File: tb/i2c_addr_matcher_test.sv
module i2c_addr_matcher_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] rd_sel = 2'd0;
    logic [7:0] rd_data;
    logic       addr_valid = 1'b0;
    logic [7:0] addr_byte = 8'd0;
    logic       match_pulse;
    logic [1:0] match_kind;

    int total = 0;
    int bad = 0;
    string tag = "R1";

    always #2 clk = ~clk;

    i2c_addr_matcher uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .addr_valid(addr_valid), .addr_byte(addr_byte),
        .match_pulse(match_pulse), .match_kind(match_kind)
    );

    // behavioural reference state
    int m_prim = 0, m_rng = 0, exp_kind = 0;
    bit m_ren = 0, m_win = 0, m_aen = 0, exp_pulse = 0;

    always @(posedge clk) begin
        int a, k;
        if (!rst_n) begin
            m_prim = 0; m_rng = 0; m_ren = 0; m_win = 0; m_aen = 0;
            exp_pulse = 0; exp_kind = 0;
        end else begin
            a = int'(addr_byte) / 2;
            k = 0;
            if (addr_valid) begin
                if (a == m_prim) k = 1;
                else if (m_ren && m_win && a >= m_prim && a <= m_rng) k = 2;
                else if (m_ren && !m_win && a == m_rng) k = 2;
                else if (m_aen && a == 12) k = 3;
            end
            exp_pulse = (k != 0);
            exp_kind = k;
            if (wr_en) begin
                if (wr_sel == 2'd0) m_prim = int'(wr_data) / 2;
                else if (wr_sel == 2'd1) begin
                    m_rng = int'(wr_data) / 2;
                    m_ren = (m_rng != 0);
                end else if (wr_sel == 2'd2) begin
                    m_win = wr_data[0];
                    m_aen = wr_data[1];
                end
            end
        end
    end

    function automatic int exp_rd(input int sel);
        case (sel)
            0: return m_prim * 2;
            1: return m_rng * 2;
            2: return int'(m_aen) * 2 + int'(m_win);
            default: return 0;
        endcase
    endfunction

    // compared on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            total++;
            if (match_pulse !== exp_pulse || int'(match_kind) != exp_kind) begin
                bad++;
                $display("FAIL %s match: pulse=%0b kind=%0d expected pulse=%0b kind=%0d",
                         tag, match_pulse, match_kind, exp_pulse, exp_kind);
            end
            total++;
            if (int'(rd_data) != exp_rd(int'(rd_sel))) begin
                bad++;
                $display("FAIL %s readback sel=%0d: got %0h expected %0h",
                         tag, rd_sel, rd_data, exp_rd(int'(rd_sel)));
            end
        end
    end

    task automatic idle_step(input logic [1:0] rs);
        @(negedge clk); #1;
        wr_en = 0; addr_valid = 0; rd_sel = rs;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk); #1;
        addr_valid = 0; wr_en = 1; wr_sel = s; wr_data = d; rd_sel = s;
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic probe(input logic [7:0] b);
        @(negedge clk); #1;
        wr_en = 0; addr_valid = 1; addr_byte = b;
        @(negedge clk); #1;
        addr_valid = 0;
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R1: reset readback of every register, primary address zero compared
        tag = "R1";
        idle_step(2'd0); idle_step(2'd1); idle_step(2'd2); idle_step(2'd3);
        probe(8'h00); probe(8'h01); probe(8'h18); probe(8'h44);
        // R2 and R10
        tag = "R2";
        wr(2'd0, 8'hA0);
        probe(8'hA0); probe(8'hA2); probe(8'h9E);
        tag = "R10";
        probe(8'hA1);
        // R3: nonzero secondary enables an exact match
        tag = "R3";
        wr(2'd1, 8'h44);
        probe(8'h44); probe(8'h45); probe(8'h46);
        // R5: reserved bit ignored and read as zero
        tag = "R5";
        wr(2'd1, 8'h47); idle_step(2'd1);
        probe(8'h46);
        wr(2'd0, 8'hA1); idle_step(2'd0);
        // R4: zero disables, including only bit 0 set
        tag = "R4";
        wr(2'd1, 8'h00); probe(8'h00); probe(8'h46);
        wr(2'd1, 8'h46); probe(8'h46);
        wr(2'd1, 8'h01); idle_step(2'd1); probe(8'h00); probe(8'h46);
        // R6: window with inclusive limits
        tag = "R6";
        wr(2'd0, 8'h40); wr(2'd1, 8'h50); wr(2'd2, 8'h01); idle_step(2'd2);
        probe(8'h3E); probe(8'h40); probe(8'h42); probe(8'h4E);
        probe(8'h50); probe(8'h52);
        wr(2'd1, 8'h20);
        probe(8'h40); probe(8'h2A); probe(8'h20);
        wr(2'd1, 8'h00); probe(8'h42);
        // R7: alert response address gated by enable
        tag = "R7";
        wr(2'd2, 8'h00); probe(8'h18);
        wr(2'd2, 8'h02); probe(8'h18); probe(8'h19); probe(8'h1A);
        // R8: priority among overlapping rules
        tag = "R8";
        wr(2'd1, 8'h18); probe(8'h18);
        wr(2'd0, 8'h18); probe(8'h18);
        wr(2'd0, 8'h10); wr(2'd2, 8'h03); wr(2'd1, 8'h30);
        probe(8'h18); probe(8'h10); probe(8'h32);
        // R9: back-to-back strobes, pulse lasts one cycle
        tag = "R9";
        @(negedge clk); #1; addr_valid = 1; addr_byte = 8'h10;
        @(negedge clk); #1; addr_byte = 8'h7E;
        @(negedge clk); #1; addr_byte = 8'h20;
        @(negedge clk); #1; addr_valid = 0;
        idle_step(2'd0); idle_step(2'd0);
        // R11: write and strobe in the same cycle use the old value
        tag = "R11";
        @(negedge clk); #1;
        wr_en = 1; wr_sel = 2'd0; wr_data = 8'h60; addr_valid = 1; addr_byte = 8'h10;
        @(negedge clk); #1;
        wr_en = 0; addr_byte = 8'h60;
        @(negedge clk); #1; addr_valid = 0;
        idle_step(2'd0); idle_step(2'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule